// File: doc/BRIEF.md
# Single-Line External Interrupt Controller

This block takes one asynchronous interrupt line from outside the chip, for example the urgent-event pin of a power-management companion device, and turns it into one clean interrupt request for the processor's main interrupt controller. The pin passes through a two-flop synchronizer. A programmable trigger stage then watches it for an active-low level, an active-high level, a falling edge or a rising edge. A detected event sets a pending flag. The flag is ANDed with an enable bit, and the result is registered onto the interrupt output.

Software uses a plain single-cycle read/write bus to reach three 32-bit registers: trigger selection, pending/acknowledge and enable. Read data is combinational from the address. A writing access commits on the rising clock edge where select and write are both high. The `LAYOUT` parameter selects where the three registers sit in the address space, so one design fits two address maps.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the trigger field is 0, the enable bit is 0, the pending bit is 0 and `irq_out` is 0. A pin held high through reset does not set pending.
- R2: Control register bits [1:0] hold the trigger: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge. Bits [31:2] read as zero, and writing them has no effect on bits [1:0].
- R3: With `LAYOUT`=0 the control, pending and enable registers sit at byte offsets 0x00, 0x04 and 0x08. With `LAYOUT`=1 they sit at 0x0C, 0x10 and 0x40.
- R4: Pending is bit 0 of the pending register. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R5: In the edge modes (1 and 3), an edge of the selected direction on the synchronized pin sets pending. Pending then stays set, even after the pin returns to idle, until software acknowledges it.
- R6: In the level modes (0 and 2), pending equals the active-level condition of the synchronized pin one clock earlier. An acknowledge written while the level is still active clears pending for one clock, and pending is set again on the following clock.
- R7: Enable is bit 0 of the enable register. `irq_out` is a register that takes pending AND enable one clock later, so `irq_out` is 0 whenever enable is 0.
- R8: Reads of an offset that maps to no register return zero. Writes to such an offset change no register.
- R9: A pin change made away from a clock edge shows in the pending bit after the third rising edge, and in `irq_out` after the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 1 | Asynchronous external interrupt line |
| bus_sel | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (0 when no read hits a register) |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that the bus keeps its signals steady around the rising edge and that `irq_pin` stays constant for at least two clocks between changes. A shorter pulse could be lost in the synchronizer, and the edge properties only speak about edges seen after synchronization. The bench changes the pin only on falling clock edges and holds each value for at least six clocks. It issues acknowledges only after the pin has settled, so an edge and an acknowledge never land on the same edge unless a test intends it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HIGH  = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PEND = 2'd1,
    REG_EN   = 2'd2
  } reg_id_e;

  // Byte offset of a register in the chosen address layout
  function automatic logic [7:0] reg_offset(input int layout, input reg_id_e id);
    logic [7:0] off;
    if (layout == 0) begin
      case (id)
        REG_CTRL: off = 8'h00;
        REG_PEND: off = 8'h04;
        default:  off = 8'h08;
      endcase
    end else begin
      case (id)
        REG_CTRL: off = 8'h0C;
        REG_PEND: off = 8'h10;
        default:  off = 8'h40;
      endcase
    end
    return off;
  endfunction

  // Mode encodings: bit 0 picks edge sensitivity, bit 1 picks high polarity
  function automatic logic trig_is_edge(input trig_e t);
    return t[0];
  endfunction

  function automatic logic trig_high(input trig_e t);
    return t[1];
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
  import ext_irq_pkg::*;
#(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_s,
  input  trig_e mode,
  input  logic  ack,
  output logic  pend,
  output logic  edge_evt,
  output logic  lvl_active
);

  logic prev_q;
  logic rise, fall;
  logic pend_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else        prev_q <= pin_s;
  end

  assign rise       = pin_s & ~prev_q;
  assign fall       = ~pin_s & prev_q;
  assign edge_evt   = trig_is_edge(mode) & (trig_high(mode) ? rise : fall);
  assign lvl_active = ~trig_is_edge(mode) & (pin_s == trig_high(mode));

  always_comb begin
    if (trig_is_edge(mode)) pend_n = edge_evt | (pend & ~ack);
    else                    pend_n = lvl_active & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_n;
  end

  // R5
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> pend);

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && trig_is_edge(mode) && !ack) |=> pend);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_evt) |=> !pend);

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_is_edge(mode) && !ack) |=> (pend == $past(lvl_active)));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int LAYOUT      = 0,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(reg_offset(LAYOUT, REG_CTRL));
  localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(reg_offset(LAYOUT, REG_PEND));
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(reg_offset(LAYOUT, REG_EN));

  trig_e ctrl_q;
  logic  en_q;
  logic  irq_q;
  logic  pin_s;
  logic  pend;
  logic  edge_evt, lvl_active;

  // Named decode events
  logic hit_ctrl, hit_pend, hit_en, any_hit;
  logic wr_ctrl, wr_en, ack_evt, rd_ctrl;
  logic unused_wdata;

  assign hit_ctrl = (bus_addr == OFF_CTRL);
  assign hit_pend = (bus_addr == OFF_PEND);
  assign hit_en   = (bus_addr == OFF_EN);
  assign any_hit  = hit_ctrl | hit_pend | hit_en;

  assign wr_ctrl  = bus_sel & bus_we & hit_ctrl;
  assign wr_en    = bus_sel & bus_we & hit_en;
  assign ack_evt  = bus_sel & bus_we & hit_pend & bus_wdata[0];
  assign rd_ctrl  = bus_sel & ~bus_we & hit_ctrl;

  assign unused_wdata = ^bus_wdata[DATA_W-1:2];

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (irq_pin),
    .q_sync  (pin_s)
  );

  irq_trigger #(.IDLE_VAL(1'b1)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_s      (pin_s),
    .mode       (ctrl_q),
    .ack        (ack_evt),
    .pend       (pend),
    .edge_evt   (edge_evt),
    .lvl_active (lvl_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= TRIG_LVL_LOW;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= trig_e'(bus_wdata[1:0]);
      if (wr_en)   en_q   <= bus_wdata[0];
      irq_q <= pend & en_q;
    end
  end

  assign irq_out = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (hit_ctrl)      bus_rdata = DATA_W'(ctrl_q);
      else if (hit_pend) bus_rdata = DATA_W'(pend);
      else if (hit_en)   bus_rdata = DATA_W'(en_q);
    end
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_out);

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en_q) |=> irq_out);

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !any_hit) |-> (bus_rdata == '0));

  // R2
  ctrl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (bus_rdata[DATA_W-1:2] == '0));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(bus_wdata[1:0])));

endmodule

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;

  localparam int AW = 8;
  localparam int DW = 32;
  // LAYOUT 0 offsets
  localparam logic [7:0] A_CTRL = 8'h00, A_PEND = 8'h04, A_EN = 8'h08;
  // LAYOUT 1 offsets
  localparam logic [7:0] B_CTRL = 8'h0C, B_PEND = 8'h10, B_EN = 8'h40;

  // {mode[1:0], pin_before, pin_after, enable, exp_pend, exp_irq}
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    7'b00_1_0_1_1_1, 7'b00_0_1_1_0_0, 7'b00_1_0_0_1_0,
    7'b01_1_0_1_1_1, 7'b01_0_1_1_0_0, 7'b01_0_0_1_0_0,
    7'b10_0_1_1_1_1, 7'b10_1_0_1_0_0, 7'b10_0_1_0_1_0,
    7'b11_0_1_1_1_1, 7'b11_1_0_1_0_0, 7'b11_1_1_1_0_0,
    7'b11_0_1_0_1_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_pin = 1'b1;
  logic a_sel = 1'b0, a_we = 1'b0;
  logic [AW-1:0] a_addr = '0;
  logic [DW-1:0] a_wdata = '0, a_rdata;
  logic a_irq;
  logic b_sel = 1'b0, b_we = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0, b_rdata;
  logic b_irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.LAYOUT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
    .bus_sel(a_sel), .bus_we(a_we), .bus_addr(a_addr),
    .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq_out(a_irq));

  ext_irq_ctrl #(.LAYOUT(1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
    .bus_sel(b_sel), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq_out(b_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write: drive at a falling edge, commit on the next rising edge
  task automatic wr(input bit side_b, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    if (side_b) begin b_sel = 1; b_we = 1; b_addr = addr; b_wdata = data; end
    else        begin a_sel = 1; a_we = 1; a_addr = addr; a_wdata = data; end
    @(negedge clk);
    a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
  endtask

  // Read: combinational, sampled at the current time (caller sits at a falling edge)
  task automatic rd(input bit side_b, input logic [7:0] addr, output logic [31:0] data);
    if (side_b) begin b_sel = 1; b_we = 0; b_addr = addr; end
    else        begin a_sel = 1; a_we = 0; a_addr = addr; end
    #0.5;
    data = side_b ? b_rdata : a_rdata;
    a_sel = 0; b_sel = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    settle(3);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state, pin held high
    rd(0, A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(0, A_EN, v);   chk("R1 enable", v, 0);
    rd(0, A_PEND, v); chk("R1 pending", v, 0);
    chk("R1 irq_out", {31'b0, a_irq}, 0);

    // Table: trigger modes x pin transitions x enable
    for (int i = 0; i < NV; i++) begin
      logic [6:0] e;
      string tag;
      e = VEC[i];
      tag = e[6] ? (e[5] ? "R5 rise" : "R6 high") : (e[5] ? "R5 fall" : "R6 low");
      wr(0, A_CTRL, {30'b0, e[6:5]});
      wr(0, A_EN, {31'b0, e[2]});
      irq_pin = e[4];
      settle(6);
      wr(0, A_PEND, 32'h1);
      irq_pin = e[3];
      settle(6);
      rd(0, A_PEND, v); chk({tag, " R2 pending"}, v, {31'b0, e[1]});
      chk({tag, " R7 irq_out"}, {31'b0, a_irq}, {31'b0, e[0]});
    end

    // R2 upper control bits ignored and read as zero
    wr(0, A_CTRL, 32'hFFFF_FFFE);
    rd(0, A_CTRL, v); chk("R2 ctrl upper bits", v, 32'h2);

    // R4 / R5 edge pending sticky, write 0 no effect, write 1 clears
    wr(0, A_EN, 32'h0);
    wr(0, A_CTRL, 32'h3);
    irq_pin = 1'b0; settle(6);
    wr(0, A_PEND, 32'h1);
    irq_pin = 1'b1; settle(6);
    irq_pin = 1'b0; settle(6);
    rd(0, A_PEND, v); chk("R5 sticky after pin idle", v, 1);
    wr(0, A_PEND, 32'hFFFF_FFFE);
    rd(0, A_PEND, v); chk("R4 write 0 keeps pending", v, 1);
    // R7 enable turned on with pending set: irq one clock after
    wr(0, A_EN, 32'h1);
    chk("R7 irq not yet", {31'b0, a_irq}, 0);
    @(negedge clk);
    chk("R7 irq after enable", {31'b0, a_irq}, 1);
    wr(0, A_PEND, 32'h1);
    rd(0, A_PEND, v); chk("R4 ack clears", v, 0);

    // R6 acknowledge while low level still active
    wr(0, A_CTRL, 32'h0);
    settle(4);
    wr(0, A_PEND, 32'h1);
    rd(0, A_PEND, v); chk("R6 cleared right after ack", v, 0);
    @(negedge clk);
    rd(0, A_PEND, v); chk("R6 set again next clock", v, 1);

    // R8 unmapped access
    wr(0, A_CTRL, 32'h1);
    wr(0, 8'h20, 32'hFFFF_FFFF);
    rd(0, 8'h20, v); chk("R8 unmapped read", v, 0);
    rd(0, A_CTRL, v); chk("R8 unmapped write ignored", v, 1);
    rd(0, B_CTRL, v); chk("R8 other-layout offset", v, 0);

    // R3 alternate layout
    wr(1, B_CTRL, 32'h3);
    rd(1, B_CTRL, v); chk("R3 layout1 ctrl", v, 3);
    wr(1, B_EN, 32'h1);
    rd(1, B_EN, v); chk("R3 layout1 enable", v, 1);
    rd(1, A_CTRL, v); chk("R3 layout1 offset 0x00 unmapped", v, 0);
    rd(1, A_EN, v); chk("R3 layout1 offset 0x08 unmapped", v, 0);
    wr(1, B_PEND, 32'h1);
    rd(1, B_PEND, v); chk("R3 layout1 pending", v, 0);

    // R9 synchronizer latency, high-level mode
    wr(0, A_CTRL, 32'h2);
    wr(0, A_EN, 32'h1);
    irq_pin = 1'b0; settle(6);
    irq_pin = 1'b1;
    settle(2);
    rd(0, A_PEND, v); chk("R9 pending after 2 edges", v, 0);
    settle(1);
    rd(0, A_PEND, v); chk("R9 pending after 3 edges", v, 1);
    chk("R9 irq after 3 edges", {31'b0, a_irq}, 0);
    settle(1);
    chk("R9 irq after 4 edges", {31'b0, a_irq}, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule